// File: doc/BRIEF.md
# Latched Interrupt Request and Vector Unit

This block gathers three interrupt sources for a small 8-bit CPU core and presents them as one request line plus a vector address. The three sources are a falling-edge external pin, a video line-compare event and a serial-bus byte-complete event. Each source is held in its own pending state. Pending states are gated by per-source enables and by the CPU's global mask bit. A fixed priority then picks which vector pair the CPU should fetch.

The external pin may be shared by several open-drain sources. For that reason a low level still requests service after the edge latch has been cleared. The external and video latches clear themselves when the CPU reads either byte of their vector pair. The serial-bus request follows a status flag that software clears by writing 0 to it. A small register write port holds the video enable, the line compare value and the serial-bus enable, and it gives access to the status flag.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `irq_req` is 0, `vec_addr` is 0 and `bus_status` reads 8'h81.
- R2: A falling edge on `ext_irq_n` seen at a clock edge sets the external latch. The latch holds after the pin returns high. With the mask clear, `irq_req` is 1 and `vec_addr` equals `VEC_EXT`.
- R3: A read (`cpu_rd`) of either byte of the external vector pair (`VEC_EXT` or `VEC_EXT`+1) clears the external latch at that edge. While the pin is held low, the latch can be set again while the mask is set, and a second pulse in that time adds nothing. Exactly one request remains and is served once the mask clears.
- R4: While `ext_irq_n` is low, the external source requests service even when its latch has just been cleared by a vector fetch.
- R5: `xfer_done` sets the serial-bus flag, which appears in `bus_status` bit 1. `bus_status` bit 7 (transfer complete) and bit 0 always read 1, and bits 6..2 read 0. The flag requests service with vector `VEC_BUS` only when the bus enable is set. The bus enable is `reg_wdata` bit 7 written with `reg_sel`=2.
- R6: A write with `reg_sel`=3 and `reg_wdata` bit 1 = 0 clears the serial-bus flag, so the request drops after that edge. A write with bit 1 = 1 leaves the flag unchanged. A `xfer_done` in the same cycle takes precedence over the clear.
- R7: The video enable is `reg_wdata` bit 7 written with `reg_sel`=0. The compare value is `reg_wdata[LINE_W-1:0]` written with `reg_sel`=1. With the enable set, a change of `line_cnt` to the compare value sets the video latch, which requests service with vector `VEC_VID`. With the enable clear, a match is not latched. A read of either byte of the `VEC_VID` pair clears the latch.
- R8: A match that persists on the same line does not set the video latch again after a vector fetch cleared it. The next change of `line_cnt` to the compare value sets it again.
- R9: When more than one source is pending, `vec_addr` selects the external source first, then the serial bus, then video.
- R10: While `cpu_imask` is 1, `irq_req` is 0 and `vec_addr` is 0. Pending latches are kept and request service once the mask clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 1 | External interrupt pin, active low, may be wired-OR |
| cpu_imask | input | 1 | CPU global interrupt mask bit |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU read address |
| line_cnt | input | LINE_W | Horizontal line counter value |
| xfer_done | input | 1 | Serial-bus byte transfer complete pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 video control, 1 compare, 2 bus control, 3 bus status |
| reg_wdata | input | 8 | Register write data |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_addr | output | ADDR_W | Address of the high byte of the selected vector pair, 0 when idle |
| bus_status | output | 8 | Serial-bus status byte |

## Verification
The bench builds the unit with `LINE_W`=4 and the default 16-bit vector addresses. The narrow counter lets a few table rows move the line counter onto, off and back onto the compare value, which exercises the once-per-line rule and the disabled-compare case. The vector table steps the sources through overlapping pendings, masked windows and vector fetches. Directed steps then cover a fetch of the low vector byte and a reset that restores the status byte.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int              LINE_W  = 8,
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_EXT = 16'h3FFA,
  parameter logic [ADDR_W-1:0] VEC_BUS = 16'h3FF2,
  parameter logic [ADDR_W-1:0] VEC_VID = 16'h3FF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_n,
  input  logic              cpu_imask,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              xfer_done,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic              irq_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [7:0]        bus_status
);
  localparam int PAIR_W = ADDR_W - 1;

  logic              ext_q, ext_lat, vid_lat, mif, vid_en, bus_ien;
  logic [LINE_W-1:0] cmp_val, line_q;

  wire fetch_ext = cpu_rd && (cpu_addr[ADDR_W-1:1] == VEC_EXT[ADDR_W-1:1]);
  wire fetch_vid = cpu_rd && (cpu_addr[ADDR_W-1:1] == VEC_VID[ADDR_W-1:1]);
  wire ext_fall  = ext_q & ~ext_irq_n;
  wire line_hit  = vid_en && (line_cnt != line_q) && (line_cnt == cmp_val);
  wire mif_clr   = reg_we && (reg_sel == 2'd3) && !reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b1;
      ext_lat <= 1'b0;
      vid_lat <= 1'b0;
      mif     <= 1'b0;
      vid_en  <= 1'b0;
      bus_ien <= 1'b0;
      cmp_val <= '0;
      line_q  <= '0;
    end else begin
      ext_q   <= ext_irq_n;
      line_q  <= line_cnt;
      ext_lat <= ext_fall | (ext_lat & ~fetch_ext);
      vid_lat <= line_hit | (vid_lat & ~fetch_vid);
      if (xfer_done)    mif <= 1'b1;
      else if (mif_clr) mif <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          2'd0:    vid_en  <= reg_wdata[7];
          2'd1:    cmp_val <= reg_wdata[LINE_W-1:0];
          2'd2:    bus_ien <= reg_wdata[7];
          default: ;
        endcase
      end
    end
  end

  wire p_ext = ext_lat | ~ext_irq_n;
  wire p_bus = mif & bus_ien;
  wire p_vid = vid_lat & vid_en;

  assign irq_req    = ~cpu_imask & (p_ext | p_bus | p_vid);
  assign vec_addr   = !irq_req ? '0 : p_ext ? VEC_EXT : p_bus ? VEC_BUS : VEC_VID;
  assign bus_status = {1'b1, 5'b0, mif, 1'b1};

  // R5: a completed byte always leaves the flag set
  a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> bus_status[1]);

  // R6: writing 0 to the flag clears it unless a byte completes
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mif_clr && !xfer_done) |=> !bus_status[1]);

  // R3: fetch with the pin high empties the external latch
  a_r3_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ext && ext_irq_n) |=> !ext_lat);

  // R8: a fetch on an unchanged line leaves the video latch empty
  a_r8_once_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vid && line_cnt == line_q) |=> !vid_lat);

  // R10: mask keeps the request line low
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_imask |-> (!irq_req && vec_addr == '0));

  // R9: a request always names one of the three vector pairs
  a_r9_vector_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (vec_addr == VEC_EXT || vec_addr == VEC_BUS || vec_addr == VEC_VID));

  // R4: a low pin with the mask clear is never ignored
  a_r4_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_irq_n && !cpu_imask) |-> (irq_req && vec_addr == VEC_EXT));

  logic [PAIR_W-1:0] unused_pair;
  assign unused_pair = VEC_BUS[ADDR_W-1:1];
endmodule

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  localparam int LW = 4;
  localparam int AW = 16;
  localparam logic [AW-1:0] VE = 16'h3FFA, VB = 16'h3FF2, VV = 16'h3FF8;

  logic clk = 0, rst_n = 0;
  logic ext_irq_n = 1, cpu_imask = 0, cpu_rd = 0, xfer_done = 0, reg_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [LW-1:0] line_cnt = '0;
  logic [1:0]    reg_sel = '0;
  logic [7:0]    reg_wdata = '0;
  logic          irq_req;
  logic [AW-1:0] vec_addr;
  logic [7:0]    bus_status;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_unit #(.LINE_W(LW), .ADDR_W(AW), .VEC_EXT(VE), .VEC_BUS(VB), .VEC_VID(VV)) dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .cpu_imask(cpu_imask),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .line_cnt(line_cnt), .xfer_done(xfer_done),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .irq_req(irq_req), .vec_addr(vec_addr), .bus_status(bus_status));

  function automatic logic [AW-1:0] vsel(input logic [1:0] s);
    case (s)
      2'd1: return VE;
      2'd2: return VB;
      2'd3: return VV;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {req id, ext_n, mask, xfer, rd, rsel, we, sel, wdata, line, exp_req, exp_vec}
  localparam int N = 37;
  localparam logic [27:0] TBL [N] = '{
    {4'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0}, // R1 idle
    {4'd7, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,8'h80,4'd0,1'b0,2'd0}, // R7 video enable
    {4'd7, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd1,8'h05,4'd0,1'b0,2'd0}, // R7 compare 5
    {4'd5, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd2,8'h80,4'd0,1'b0,2'd0}, // R5 bus enable
    {4'd2, 1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd1}, // R2 pin falls
    {4'd2, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd1}, // R2 latch holds
    {4'd10,1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0}, // R10 masked
    {4'd3, 1'b1,1'b0,1'b0,1'b1,2'd1,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0}, // R3 fetch clears
    {4'd3, 1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0}, // R3 pulse in service
    {4'd3, 1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0},
    {4'd3, 1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0}, // R3 second pulse
    {4'd3, 1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0},
    {4'd3, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd1}, // R3 queued served
    {4'd3, 1'b1,1'b0,1'b0,1'b1,2'd1,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0}, // R3 only one queued
    {4'd4, 1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd1}, // R4 pin low
    {4'd4, 1'b0,1'b0,1'b0,1'b1,2'd1,1'b0,2'd0,8'h00,4'd0,1'b1,2'd1}, // R4 still low after fetch
    {4'd4, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b0,2'd0},
    {4'd5, 1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd2}, // R5 byte done
    {4'd5, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd2},
    {4'd9, 1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd0,1'b1,2'd1}, // R9 ext over bus
    {4'd9, 1'b1,1'b0,1'b0,1'b1,2'd1,1'b0,2'd0,8'h00,4'd0,1'b1,2'd2},
    {4'd6, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd3,8'h02,4'd0,1'b1,2'd2}, // R6 write 1 keeps
    {4'd6, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd3,8'h00,4'd0,1'b0,2'd0}, // R6 write 0 clears
    {4'd7, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b1,2'd3}, // R7 line match
    {4'd7, 1'b1,1'b0,1'b0,1'b1,2'd3,1'b0,2'd0,8'h00,4'd5,1'b0,2'd0}, // R7 fetch clears
    {4'd8, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b0,2'd0}, // R8 same line
    {4'd8, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd6,1'b0,2'd0},
    {4'd8, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b1,2'd3}, // R8 new match
    {4'd9, 1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b1,2'd2}, // R9 bus over video
    {4'd10,1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b0,2'd0}, // R10 masked
    {4'd10,1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd3,8'h00,4'd5,1'b1,2'd3}, // R10 video kept
    {4'd7, 1'b1,1'b0,1'b0,1'b1,2'd3,1'b0,2'd0,8'h00,4'd5,1'b0,2'd0},
    {4'd7, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,8'h00,4'd5,1'b0,2'd0}, // R7 video off
    {4'd7, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd7,1'b0,2'd0},
    {4'd7, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b0,2'd0}, // R7 match not latched
    {4'd5, 1'b1,1'b0,1'b0,1'b0,2'd0,1'b1,2'd2,8'h00,4'd5,1'b0,2'd0}, // R5 bus off
    {4'd5, 1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,8'h00,4'd5,1'b0,2'd0}  // R5 flag without enable
  };

  task automatic idle();
    ext_irq_n = 1; cpu_imask = 0; xfer_done = 0; cpu_rd = 0; cpu_addr = '0; reg_we = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset req", 32'(irq_req), 32'd0);
    chk("R1 reset vec", 32'(vec_addr), 32'd0);
    chk("R1 reset status", 32'(bus_status), 32'h81);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < N; i++) begin
      logic [27:0] r;
      r = TBL[i];
      @(negedge clk);
      ext_irq_n = r[23]; cpu_imask = r[22]; xfer_done = r[21]; cpu_rd = r[20];
      cpu_addr = vsel(r[19:18]); reg_we = r[17]; reg_sel = r[16:15];
      reg_wdata = r[14:7]; line_cnt = r[6:3];
      @(posedge clk); #1;
      chk($sformatf("R%0d step %0d", r[27:24], i),
          {15'd0, irq_req, vec_addr}, {15'd0, r[2], vsel(r[1:0])});
    end

    @(negedge clk); idle();
    @(posedge clk); #1;
    chk("R5 status flag", 32'(bus_status), 32'h83);

    // R3: fetch of the low vector byte also clears
    @(negedge clk); ext_irq_n = 0;
    @(negedge clk); ext_irq_n = 1;
    @(posedge clk); #1;
    chk("R2 latched after pulse", {15'd0, irq_req, vec_addr}, {15'd0, 1'b1, VE});
    @(negedge clk); cpu_rd = 1; cpu_addr = VE + 16'd1;
    @(posedge clk); #1;
    chk("R3 low byte fetch", 32'(irq_req), 32'd0);
    @(negedge clk); idle();

    // R6: byte completion wins over a clearing write
    @(negedge clk); xfer_done = 1; reg_we = 1; reg_sel = 2'd3; reg_wdata = 8'h00;
    @(posedge clk); #1;
    chk("R6 set wins", 32'(bus_status), 32'h83);
    @(negedge clk); idle();

    // R1: reset restores status
    @(negedge clk); rst_n = 0;
    #1;
    chk("R1 reset mid run", {16'd0, bus_status, 7'd0, irq_req}, {16'd0, 8'h81, 7'd0, 1'b0});
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule